// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers thirty-two interrupt request lines into two processor-facing requests, one critical and one non-critical, and computes in hardware the address of the handler for the most urgent pending source. Each line is first passed through a two-flop synchronizer. It is then normalised to active-true according to a per-source polarity bit, and qualified as level- or edge-sensitive according to a per-source trigger bit. A qualifying event sets a sticky pending bit, and software clears that bit by writing 1 to it.

Software reaches the block over a simple word-addressed register bus. A write strobe takes effect at the next rising clock edge. Read data is combinational from the current register state. A per-source enable masks pending bits before they reach the outputs. A per-source critical bit chooses which of the two request outputs a source drives. A vector configuration register supplies a handler base address, and its bit 0 chooses which end of the source field wins. The vector is that base plus 512 bytes for each step of the winning source's rank.

Top module: `ivc_top`

## Requirements
- R1: While reset is held, and at the first edge after it, every writable register reads zero. Neither request output is asserted and the vector reads zero. Registers not listed below, and the status-set register, read zero.
- R2: Source n maps to bit (31 − n) of every register and of the `irq_src` input, so source 0 is the most significant bit.
- R3: A polarity bit of 1 makes its source active when the input is high. A polarity bit of 0 makes it active when the input is low.
- R4: For a level-sensitive source (trigger bit 0), the pending bit in status (offset 0x00) sets while the source is active. Writing 1 to a status bit clears it, and the clear wins over a simultaneous set. While the level persists, the bit reads 0 for exactly one cycle and then reads 1 again.
- R5: For an edge-sensitive source (trigger bit 1), the pending bit sets only on a transition into the active state and holds until cleared. An input that stays active after a clear does not set it again.
- R6: A change on `irq_src` sampled at edge k is first visible in status after edge k+2.
- R7: Writing 1s to the status-set register (offset 0x04) forces those status bits to 1. Writing 0s there has no effect.
- R8: The masked status register (offset 0x18) reads status AND enable (enable at offset 0x08).
- R9: `irq_crit` is the OR of masked bits whose critical bit (offset 0x0C) is 1. `irq_noncrit` is the OR of masked bits whose critical bit is 0.
- R10: When vector configuration bit 0 is 1, source 0 has the highest priority. The vector (offset 0x1C and `irq_vector`) is (configuration with bits 1:0 cleared) + N×512 for the winning source N.
- R11: When vector configuration bit 0 is 0, source 31 has the highest priority, and the vector is the same base + (31 − N)×512.
- R12: With no masked source pending, the vector equals the base, which is the configuration with bits 1:0 cleared.
- R13: Writes to the masked status and vector registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_src | input | 32 | Raw interrupt lines, source n on bit 31−n |
| irq_crit | output | 1 | Critical interrupt request |
| irq_noncrit | output | 1 | Non-critical interrupt request |
| irq_vector | output | 32 | Handler address of the highest-priority masked pending source |

## Verification
The assertions assume that status-clear and status-set strobes arrive only as whole-word register writes. They also assume that raw lines may change on any cycle, because the synchronizer absorbs them, and that the vector configuration may change at any time. The stimulus drives bus and input changes one time unit after a falling edge, so each change is seen by exactly one rising edge. It writes only to the nine defined offsets. Random stimulus mixes pulses, held levels and register writes, so that clears collide with level sets and edges.

// File: rtl/ivc_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes a 32-bit data path with one register bit per source.
package ivc_pkg;
    localparam int SRC_N      = 32;
    localparam int IDX_W      = $clog2(SRC_N);
    localparam int ADDR_W     = 6;
    localparam int VEC_SHIFT  = 9;

    localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_FORCE  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_ENA    = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_CRIT   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_POL    = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_TRIG   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_VEC    = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_VCFG   = 6'h20;

    typedef struct packed {
        logic [SRC_N-1:0] enable;
        logic [SRC_N-1:0] critical;
        logic [SRC_N-1:0] polarity;
        logic [SRC_N-1:0] trigger;
        logic [SRC_N-1:0] vcfg;
    } ivc_cfg_t;
endpackage

// File: rtl/ivc_regs.sv
// Configuration register file and write-strobe decode.
// Assumes word writes only; status clear/set are presented as one-cycle masks.
module ivc_regs
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_N-1:0]  wdata,
    output ivc_cfg_t          cfg,
    output logic [SRC_N-1:0]  clr_mask,
    output logic [SRC_N-1:0]  set_mask
);
    // Store configuration writes; read-only offsets fall through untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_ENA:  cfg.enable   <= wdata;
                OFF_CRIT: cfg.critical <= wdata;
                OFF_POL:  cfg.polarity <= wdata;
                OFF_TRIG: cfg.trigger  <= wdata;
                OFF_VCFG: cfg.vcfg     <= wdata;
                default:  ;
            endcase
        end
    end

    // Turn status-clear and status-set writes into per-source strobes.
    always_comb begin
        clr_mask = (wr_en && addr == OFF_STAT)  ? wdata : '0;
        set_mask = (wr_en && addr == OFF_FORCE) ? wdata : '0;
    end
endmodule

// File: rtl/ivc_cond.sv
// Input conditioning: two-flop synchronizer, polarity normalisation and
// level/edge qualification per source. Assumes raw inputs are asynchronous.
module ivc_cond
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] raw_in,
    input  logic [SRC_N-1:0] polarity,
    input  logic [SRC_N-1:0] trigger,
    output logic [SRC_N-1:0] hw_set
);
    logic [SRC_N-1:0] rise;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        logic meta_q, sync_q, prev_act_q, act;

        // Normalise the synchronized line to active-true.
        assign act = ~(sync_q ^ polarity[g]);

        // Synchronize the raw line and remember the previous active state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q     <= 1'b0;
                sync_q     <= 1'b0;
                prev_act_q <= 1'b0;
            end else begin
                meta_q     <= raw_in[g];
                sync_q     <= meta_q;
                prev_act_q <= act;
            end
        end

        // Level sources request while active; edge sources on entry only.
        assign rise[g]   = act & ~prev_act_q;
        assign hw_set[g] = trigger[g] ? rise[g] : act;
    end

    // R5: with a fixed polarity, a source cannot report entry twice in a row.
    p_edge_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $stable(polarity)) |=> ((rise & $past(rise)) == '0 || !$stable(polarity)))
        else $error("edge detected on consecutive cycles");
endmodule

// File: rtl/ivc_status.sv
// Sticky pending-status latch. A software clear beats a hardware set in the
// same cycle; a software force beats both. Assumes one-cycle strobes.
module ivc_status
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] hw_set,
    input  logic [SRC_N-1:0] clr_mask,
    input  logic [SRC_N-1:0] set_mask,
    output logic [SRC_N-1:0] status
);
    // Latch requests, apply clears, then apply forced sets.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status | hw_set) & ~clr_mask) | set_mask;
    end

    // R4: without a clear, pending bits never drop.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_mask == '0) |=> ((status & $past(status)) == $past(status)))
        else $error("pending bit dropped without a clear");

    // R4: clearing everything with no set in flight empties status.
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_mask == '1 && set_mask == '0) |=> (status == '0))
        else $error("full clear left bits pending");

    // R7: forced bits are pending on the following cycle.
    p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && set_mask != '0) |=> ((status & $past(set_mask)) == $past(set_mask)))
        else $error("forced bit not pending");
endmodule

// File: rtl/ivc_prio.sv
// Priority encoder and vector arithmetic. Direction bit 1 favours source 0
// (the MSB); bit 0 favours source 31 (the LSB). Purely combinational.
module ivc_prio
    import ivc_pkg::*;
(
    input  logic [SRC_N-1:0] masked,
    input  logic [SRC_N-1:0] vcfg,
    output logic [SRC_N-1:0] vector
);
    logic [IDX_W-1:0] rank;
    logic [SRC_N-1:0] base;

    // Find the winner's rank: its distance from the favoured end.
    always_comb begin
        rank = '0;
        if (vcfg[0]) begin
            for (int i = 0; i < SRC_N; i++)
                if (masked[i]) rank = IDX_W'(SRC_N - 1 - i);
        end else begin
            for (int i = SRC_N - 1; i >= 0; i--)
                if (masked[i]) rank = IDX_W'(i);
        end
    end

    // Add the stride-scaled rank to the word-aligned base.
    always_comb begin
        base   = vcfg & ~SRC_N'(3);
        vector = base + (SRC_N'(rank) << VEC_SHIFT);
    end
endmodule

// File: rtl/ivc_top.sv
// Vectored interrupt controller top: register bus, conditioning, status,
// request outputs and vector. Assumes bus_addr is a byte offset, word aligned.
module ivc_top
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SRC_N-1:0]  bus_wdata,
    output logic [SRC_N-1:0]  bus_rdata,
    input  logic [SRC_N-1:0]  irq_src,
    output logic              irq_crit,
    output logic              irq_noncrit,
    output logic [SRC_N-1:0]  irq_vector
);
    ivc_cfg_t         cfg;
    logic [SRC_N-1:0] clr_mask, set_mask, hw_set, status, masked;

    ivc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg(cfg), .clr_mask(clr_mask), .set_mask(set_mask)
    );

    ivc_cond u_cond (
        .clk(clk), .rst_n(rst_n), .raw_in(irq_src), .polarity(cfg.polarity),
        .trigger(cfg.trigger), .hw_set(hw_set)
    );

    ivc_status u_status (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .clr_mask(clr_mask),
        .set_mask(set_mask), .status(status)
    );

    ivc_prio u_prio (
        .masked(masked), .vcfg(cfg.vcfg), .vector(irq_vector)
    );

    // Gate pending bits and split them between the two request outputs.
    always_comb begin
        masked      = status & cfg.enable;
        irq_crit    = |(masked & cfg.critical);
        irq_noncrit = |(masked & ~cfg.critical);
    end

    // Return the addressed register; unknown offsets and status-set read zero.
    always_comb begin
        case (bus_addr)
            OFF_STAT:   bus_rdata = status;
            OFF_ENA:    bus_rdata = cfg.enable;
            OFF_CRIT:   bus_rdata = cfg.critical;
            OFF_POL:    bus_rdata = cfg.polarity;
            OFF_TRIG:   bus_rdata = cfg.trigger;
            OFF_MASKED: bus_rdata = masked;
            OFF_VEC:    bus_rdata = irq_vector;
            OFF_VCFG:   bus_rdata = cfg.vcfg;
            default:    bus_rdata = '0;
        endcase
    end

    // R9: with both requests low, nothing enabled is pending.
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_crit && !irq_noncrit) |-> ((status & cfg.enable) == '0))
        else $error("pending enabled source without a request");

    // R12: with nothing pending, the vector is the aligned base.
    p_vec_base_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & cfg.enable) == '0) |-> (irq_vector == {cfg.vcfg[SRC_N-1:2], 2'b00}))
        else $error("idle vector differs from base");

    // R10: the vector is always word aligned and keeps the base's low bits.
    p_vec_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vector[VEC_SHIFT-1:0] == {cfg.vcfg[VEC_SHIFT-1:2], 2'b00})
        else $error("vector low bits corrupted");
endmodule

// File: tb/ivc_top_tb.sv
// Self-checking bench with a behavioural reference model compared each cycle.
module ivc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic        irq_crit, irq_noncrit;
    logic [31:0] irq_vector;

    int checks = 0;
    int fails  = 0;
    bit model_on = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ivc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .irq_crit(irq_crit), .irq_noncrit(irq_noncrit), .irq_vector(irq_vector)
    );

    // Reference model state.
    logic [31:0] m_stat, m_ena, m_crit, m_pol, m_trig, m_vcfg;
    logic [31:0] m_pipe[2];
    logic [31:0] m_prev;

    function automatic logic [31:0] m_vec(input logic [31:0] pend, input logic [31:0] cfg);
        int n_win = -1;
        logic [31:0] base = {cfg[31:2], 2'b00};
        if (cfg[0]) begin
            for (int n = 0; n < 32; n++) if (n_win < 0 && pend[31-n]) n_win = n;
            if (n_win >= 0) return base + 32'(n_win) * 512;
        end else begin
            for (int n = 31; n >= 0; n--) if (n_win < 0 && pend[31-n]) n_win = n;
            if (n_win >= 0) return base + 32'(31 - n_win) * 512;
        end
        return base;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return m_stat;
            6'h08: return m_ena;
            6'h0C: return m_crit;
            6'h10: return m_pol;
            6'h14: return m_trig;
            6'h18: return m_stat & m_ena;
            6'h1C: return m_vec(m_stat & m_ena, m_vcfg);
            6'h20: return m_vcfg;
            default: return 32'h0;
        endcase
    endfunction

    // Advance the model at each rising edge from pre-edge inputs and state.
    always @(posedge clk) begin
        logic [31:0] act, req, clr, frc;
        if (!rst_n) begin
            m_stat = 0; m_ena = 0; m_crit = 0; m_pol = 0; m_trig = 0; m_vcfg = 0;
            m_pipe[0] = 0; m_pipe[1] = 0; m_prev = 0;
        end else begin
            act = m_pol ? ~(m_pipe[1] ^ m_pol) : ~m_pipe[1];
            req = 0;
            for (int b = 0; b < 32; b++)
                req[b] = m_trig[b] ? (act[b] && !m_prev[b]) : act[b];
            clr = (bus_wr && bus_addr == 6'h00) ? bus_wdata : 0;
            frc = (bus_wr && bus_addr == 6'h04) ? bus_wdata : 0;
            m_stat = ((m_stat | req) & ~clr) | frc;
            m_prev = act;
            m_pipe[1] = m_pipe[0];
            m_pipe[0] = irq_src;
            if (bus_wr) begin
                case (bus_addr)
                    6'h08: m_ena  = bus_wdata;
                    6'h0C: m_crit = bus_wdata;
                    6'h10: m_pol  = bus_wdata;
                    6'h14: m_trig = bus_wdata;
                    6'h20: m_vcfg = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (model_on) begin
            string t;
            chk("R9 crit", {31'b0, irq_crit}, {31'b0, |(m_stat & m_ena & m_crit)});
            chk("R9 noncrit", {31'b0, irq_noncrit}, {31'b0, |(m_stat & m_ena & ~m_crit)});
            chk("R10 vector", irq_vector, m_vec(m_stat & m_ena, m_vcfg));
            case (bus_addr)
                6'h00: t = "R4 rdata";
                6'h04: t = "R13 rdata";
                6'h18: t = "R8 rdata";
                6'h1C: t = "R11 rdata";
                default: t = "R1 rdata";
            endcase
            chk(t, bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input string tag, input logic [5:0] a,
                      input logic [31:0] mask, input logic [31:0] exp);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata & mask, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_irq(input logic [31:0] v);
        @(negedge clk); #1;
        irq_src = v;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        bus_addr = 6'h08; #1 chk("R1 enable", bus_rdata, 0);
        bus_addr = 6'h1C; #1 chk("R1 vector", bus_rdata, 0);
        chk("R1 requests", {30'b0, irq_crit, irq_noncrit}, 0);
        #1 rst_n = 1;
        model_on = 1;

        // R3: polarity 0 treats a low line as active.
        idle(4);
        rd("R3 active-low", 6'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h00, 32'hFFFF_FFFF);
        idle(4);
        rd("R3 active-high idle", 6'h00, 32'hFFFF_FFFF, 0);

        // R2: source 0 is the most significant bit.
        drive_irq(32'h8000_0000);
        idle(4);
        rd("R2 source0 msb", 6'h00, 32'hFFFF_FFFF, 32'h8000_0000);
        drive_irq(0);
        wr(6'h00, 32'hFFFF_FFFF);
        idle(4);

        // R6: two-flop latency from input to status.
        rd("R6 pre", 6'h00, 32'hFFFF_FFFF, 0);
        drive_irq(32'h0000_0001);
        @(negedge clk); chk("R6 edge k", bus_rdata & 1, 0);
        @(negedge clk); chk("R6 edge k+1", bus_rdata & 1, 0);
        @(negedge clk); chk("R6 edge k+2", bus_rdata & 1, 1);

        // R4: clear wins for one cycle, then the held level re-sets.
        wr(6'h00, 32'h0000_0001);
        @(negedge clk); chk("R4 cleared", bus_rdata & 1, 0);
        @(negedge clk); chk("R4 re-set", bus_rdata & 1, 1);
        drive_irq(0);
        idle(3);
        wr(6'h00, 32'hFFFF_FFFF);
        idle(4);
        rd("R4 stays clear", 6'h00, 32'hFFFF_FFFF, 0);

        // R5: edge sources latch on entry only.
        wr(6'h14, 32'hFFFF_FFFF);
        drive_irq(32'h2);
        drive_irq(0);
        idle(4);
        rd("R5 pulse held", 6'h00, 32'hFFFF_FFFF, 32'h2);
        wr(6'h00, 32'h2);
        drive_irq(32'h2);
        idle(4);
        rd("R5 new edge", 6'h00, 32'hFFFF_FFFF, 32'h2);
        wr(6'h00, 32'h2);
        idle(5);
        rd("R5 held level ignored", 6'h00, 32'hFFFF_FFFF, 0);

        // R7/R13: force bits; status-set reads zero.
        wr(6'h04, 32'h0000_00F0);
        rd("R7 forced", 6'h00, 32'hFFFF_FFFF, 32'h0000_00F0);
        rd("R13 force reads zero", 6'h04, 32'hFFFF_FFFF, 0);

        // R8: masked status.
        wr(6'h08, 32'h0000_00A0);
        rd("R8 masked", 6'h18, 32'hFFFF_FFFF, 32'h0000_00A0);

        // R9: critical steering.
        wr(6'h0C, 32'h0000_0080);
        @(negedge clk); chk("R9 both", {30'b0, irq_crit, irq_noncrit}, 2'b11);
        wr(6'h0C, 32'h0000_00A0);
        @(negedge clk); chk("R9 crit only", {30'b0, irq_crit, irq_noncrit}, 2'b10);
        wr(6'h0C, 0);
        @(negedge clk); chk("R9 noncrit only", {30'b0, irq_crit, irq_noncrit}, 2'b01);

        // R10/R11: priority direction (sources 24 and 26 pending).
        wr(6'h20, 32'h0001_0003);
        rd("R10 source0 first", 6'h1C, 32'hFFFF_FFFF, 32'h0001_3000);
        wr(6'h20, 32'h0001_0002);
        rd("R11 source31 first", 6'h1C, 32'hFFFF_FFFF, 32'h0001_0A00);
        chk("R11 port", irq_vector, 32'h0001_0A00);

        // R12: idle vector is the aligned base.
        wr(6'h08, 0);
        rd("R12 idle base", 6'h1C, 32'hFFFF_FFFF, 32'h0001_0000);
        wr(6'h20, 32'h1234_5677);
        rd("R12 aligned", 6'h1C, 32'hFFFF_FFFF, 32'h1234_5674);

        // R13: read-only registers ignore writes.
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hDEAD_BEEF);
        rd("R13 masked unchanged", 6'h18, 32'hFFFF_FFFF, 0);
        rd("R13 vector unchanged", 6'h1C, 32'hFFFF_FFFF, 32'h1234_5674);

        // Mixed random traffic checked against the model each cycle.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            irq_src = ($urandom % 4 == 0) ? $urandom : irq_src;
            bus_wr = ($urandom % 3 == 0);
            bus_addr = 6'(($urandom % 9) * 4);
            bus_wdata = $urandom;
        end
        @(negedge clk); #1 bus_wr = 0;
        idle(5);
        done = 1;
        finish_run();
    end
endmodule